// File: doc/BRIEF.md
# Pin Pattern Match Event Detector

This block watches one of two input ports and raises a sticky event flag when the masked value of the chosen port enters a programmed condition. The condition is either "masked port equals the compare value" or "masked port differs from the compare value". It fires only on entry into the condition. A condition that already holds raises nothing. A configuration load is compared against the term that was true just before it, so a load that turns the term from false to true is itself an event.

Software loads the port choice, mask, compare value and sense with a one-cycle load strobe. It then either polls the pending flag or holds a wait request until a single-cycle done pulse. The done pulse also consumes the flag. An acknowledge strobe clears the flag directly.

A measurement that starts at an arbitrary moment can miss the first edge. The usual practice is to wait for the opposite condition first, then arm the detector for the edge of interest.

Top module: `patmatch_event`

## Requirements
- R1: The match term is true when `(port & cfg_mask) == cfg_value` and `cfg_sense_eq` is 1, or when that equality is false and `cfg_sense_eq` is 0.
- R2: When `cfg_use_b` is 1, port B is compared; when it is 0, port A is compared. The port that is not selected has no effect on the flag.
- R3: The flag is set only when the match term goes from false to true. A term that stays true, or goes from true to false, sets nothing.
- R4: A configuration load is an event when the term under the new settings is true and the term just before the load was false. If the term was already true before the load, no event is raised.
- R5: The ports are registered once before comparison. After an input change driven before rising edge k, the flag is still low after edge k and reads high after edge k+1.
- R6: Once set, the flag stays high until `evt_ack` is sampled high or a wait consumes it. An acknowledge clears it on the next edge.
- R7: When a set and a clear happen at the same edge, the flag stays high.
- R8: When `wait_req` is high and the flag is pending, `wait_done` is high for exactly one cycle after the next edge, and the flag is cleared at that edge.
- R9: A wait issued before any event keeps `wait_done` low. It completes one cycle after the flag sets.
- R10: After reset, the flag and `wait_done` are low. The configuration is port A, mask 0, value 0 and the equal sense, so the term is true and changes on port A do not raise an event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_a | input | 32 | First input port |
| port_b | input | 32 | Second input port |
| cfg_load | input | 1 | Strobe that loads the four configuration fields |
| cfg_use_b | input | 1 | 1 selects port B, 0 selects port A |
| cfg_mask | input | 32 | Bits of the port taking part in the compare |
| cfg_value | input | 32 | Compare value |
| cfg_sense_eq | input | 1 | 1 detects equality, 0 detects inequality |
| evt_ack | input | 1 | Clears the pending flag |
| wait_req | input | 1 | Blocking wait request, held until done |
| evt_pending | output | 1 | Sticky event flag, readable as a poll |
| wait_done | output | 1 | One-cycle completion pulse of a wait |

## Verification
The hardest situation to reach is a set and a clear at the same edge. It needs a pending flag, a fresh false-to-true entry on the compared port, and an acknowledge placed in the one cycle where the registered input has just taken the new value. The stimulus first leaves an event pending. It then drops the port out of the condition and drives it back in. One negative edge later, once the input register holds the new value, it pulses the acknowledge. It then checks that the flag is still high.

A swept run checks every transition between two 3-bit patterns. The sweep covers several masks, every compare value, both senses and both port choices. The unselected port moves in the opposite direction, so a wrong port choice would show up in the result.

// File: rtl/patmatch_pkg.sv
`timescale 1ns/1ps
package patmatch_pkg;
  localparam int unsigned NPORT = 2;

  typedef enum logic {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_sel_e;

  typedef enum logic {
    SENSE_NE = 1'b0,
    SENSE_EQ = 1'b1
  } sense_e;
endpackage

// File: rtl/patmatch_sync.sv
`timescale 1ns/1ps
module patmatch_sync
  import patmatch_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORT-1:0][W-1:0]    pins_i,
  output logic [NPORT-1:0][W-1:0]    pins_q
);
  // One register stage per port ahead of the comparator.
  for (genvar g = 0; g < NPORT; g++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pins_q[g] <= '0;
      else        pins_q[g] <= pins_i[g];
    end
  end
endmodule

// File: rtl/patmatch_cmp.sv
`timescale 1ns/1ps
module patmatch_cmp
  import patmatch_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0][W-1:0] pins_q,
  input  logic                    cfg_load,
  input  logic                    cfg_use_b,
  input  logic [W-1:0]            cfg_mask,
  input  logic [W-1:0]            cfg_value,
  input  logic                    cfg_sense_eq,
  output logic                    match_now,
  output logic                    match_prev,
  output logic                    rise_evt
);
  port_sel_e      sel_q;
  sense_e         sense_q;
  logic [W-1:0]   mask_q;
  logic [W-1:0]   value_q;
  logic [W-1:0]   chosen;

  // Match term: masked equality, inverted when inequality is requested.
  function automatic logic match_term(input logic [W-1:0] pv,
                                      input logic [W-1:0] m,
                                      input logic [W-1:0] v,
                                      input sense_e       s);
    logic same;
    same = ((pv & m) == v);
    return same ^ (s == SENSE_NE);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= PORT_A;
      sense_q <= SENSE_EQ;
      mask_q  <= '0;
      value_q <= '0;
    end else if (cfg_load) begin
      sel_q   <= port_sel_e'(cfg_use_b);
      sense_q <= sense_e'(cfg_sense_eq);
      mask_q  <= cfg_mask;
      value_q <= cfg_value;
    end
  end

  assign chosen    = (sel_q == PORT_B) ? pins_q[1] : pins_q[0];
  assign match_now = match_term(chosen, mask_q, value_q, sense_q);

  // Previous term keeps tracking through loads, so a load that turns the
  // term true is compared against the term that held before it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_prev <= 1'b1;
    else        match_prev <= match_now;
  end

  assign rise_evt = match_now & ~match_prev;

  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> ($past(cfg_load) || (pins_q != $past(pins_q)))); // R3
endmodule

// File: rtl/patmatch_flag.sv
`timescale 1ns/1ps
module patmatch_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_evt,
  input  logic evt_ack,
  input  logic wait_req,
  output logic evt_pending,
  output logic wait_done
);
  logic consume;
  logic pend_d;

  assign consume = wait_req & evt_pending & ~wait_done;

  always_comb begin
    pend_d = evt_pending;
    if (evt_ack || consume) pend_d = 1'b0;
    if (rise_evt)           pend_d = 1'b1;  // set wins
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_pending <= 1'b0;
      wait_done   <= 1'b0;
    end else begin
      evt_pending <= pend_d;
      wait_done   <= consume;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> evt_pending); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ack && !rise_evt) |=> !evt_pending); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pending && !evt_ack && !wait_req) |=> evt_pending); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wait_done |=> !wait_done); // R8
  AST_DONE_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    wait_done |-> $past(evt_pending && wait_req)); // R8
endmodule

// File: rtl/patmatch_event.sv
`timescale 1ns/1ps
module patmatch_event
  import patmatch_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] port_a,
  input  logic [W-1:0] port_b,
  input  logic         cfg_load,
  input  logic         cfg_use_b,
  input  logic [W-1:0] cfg_mask,
  input  logic [W-1:0] cfg_value,
  input  logic         cfg_sense_eq,
  input  logic         evt_ack,
  input  logic         wait_req,
  output logic         evt_pending,
  output logic         wait_done
);
  logic [NPORT-1:0][W-1:0] pins_raw;
  logic [NPORT-1:0][W-1:0] pins_q;
  logic                    match_now;
  logic                    match_prev;
  logic                    rise_evt;

  assign pins_raw[0] = port_a;
  assign pins_raw[1] = port_b;

  patmatch_sync #(.W(W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_i (pins_raw),
    .pins_q (pins_q)
  );

  patmatch_cmp #(.W(W)) u_cmp (
    .clk          (clk),
    .rst_n        (rst_n),
    .pins_q       (pins_q),
    .cfg_load     (cfg_load),
    .cfg_use_b    (cfg_use_b),
    .cfg_mask     (cfg_mask),
    .cfg_value    (cfg_value),
    .cfg_sense_eq (cfg_sense_eq),
    .match_now    (match_now),
    .match_prev   (match_prev),
    .rise_evt     (rise_evt)
  );

  patmatch_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_evt    (rise_evt),
    .evt_ack     (evt_ack),
    .wait_req    (wait_req),
    .evt_pending (evt_pending),
    .wait_done   (wait_done)
  );

  AST_FLAG_FROM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_pending) |-> $past(match_now && !match_prev)); // R3
  AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    wait_done |-> $past(wait_req)); // R9
endmodule

// File: tb/patmatch_event_test.sv
`timescale 1ns/1ps
module patmatch_event_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] port_a = '0, port_b = '0;
  logic        cfg_load = 1'b0, cfg_use_b = 1'b0, cfg_sense_eq = 1'b0;
  logic [31:0] cfg_mask = '0, cfg_value = '0;
  logic        evt_ack = 1'b0, wait_req = 1'b0;
  logic        evt_pending, wait_done;
  int          checks = 0, fails = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  patmatch_event #(.W(32)) uut (
    .clk(clk), .rst_n(rst_n), .port_a(port_a), .port_b(port_b),
    .cfg_load(cfg_load), .cfg_use_b(cfg_use_b), .cfg_mask(cfg_mask),
    .cfg_value(cfg_value), .cfg_sense_eq(cfg_sense_eq), .evt_ack(evt_ack),
    .wait_req(wait_req), .evt_pending(evt_pending), .wait_done(wait_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Bitwise restatement of the match term.
  function automatic bit ref_match(logic [31:0] p, logic [31:0] m, logic [31:0] v, bit eq_mode);
    bit same = 1'b1;
    for (int i = 0; i < 32; i++)
      if ((m[i] & p[i]) != v[i]) same = 1'b0;
    return eq_mode ? same : !same;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input bit use_b, input logic [31:0] m, input logic [31:0] v, input bit eq);
    cfg_use_b = use_b; cfg_mask = m; cfg_value = v; cfg_sense_eq = eq; cfg_load = 1'b1;
    cyc(1);
    cfg_load = 1'b0;
  endtask

  task automatic ack_pulse();
    evt_ack = 1'b1; cyc(1); evt_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R10 flag after reset", evt_pending, 0);
    chk("R10 done after reset", wait_done, 0);
    port_a = 32'hFFFF_FFFF; cyc(4);
    chk("R10 reset config no event", evt_pending, 0);

    // Equal sense on 0x12; old term (reset config) true, new false: no event.
    port_a = 32'h0;
    cyc(2);
    load(1'b0, 32'hFF, 32'h12, 1'b1);
    cyc(3);
    chk("R4 load to false no event", evt_pending, 0);

    // Latency and entry.
    port_a = 32'h12;
    cyc(1);
    chk("R5 flag low after first edge", evt_pending, 0);
    cyc(1);
    chk("R5 R3 flag high after second edge", evt_pending, 1);
    cyc(5);
    chk("R6 sticky while held", evt_pending, 1);
    port_a = 32'h0; cyc(4);
    chk("R6 sticky after leaving", evt_pending, 1);
    ack_pulse();
    chk("R6 ack clears", evt_pending, 0);

    // Held-true condition does not refire.
    port_a = 32'h12; cyc(3); ack_pulse();
    cyc(6);
    chk("R3 held true no event", evt_pending, 0);

    // Config-driven events.
    load(1'b0, 32'hFF, 32'h12, 1'b0);
    cyc(4);
    chk("R4 true to false by load", evt_pending, 0);
    load(1'b0, 32'hFF, 32'h12, 1'b1);
    chk("R4 right after load", evt_pending, 0);
    cyc(1);
    chk("R4 false to true by load", evt_pending, 1);
    ack_pulse();
    load(1'b0, 32'h0F, 32'h02, 1'b1);
    cyc(4);
    chk("R4 already true no event", evt_pending, 0);

    // Set and clear at the same edge.
    port_a = 32'h0; cyc(3); port_a = 32'h2; cyc(3);
    chk("R7 setup pending", evt_pending, 1);
    port_a = 32'h0; cyc(3);
    port_a = 32'h2; cyc(1);
    evt_ack = 1'b1; cyc(1); evt_ack = 1'b0;
    chk("R7 set wins over ack", evt_pending, 1);
    ack_pulse();
    chk("R6 plain ack", evt_pending, 0);

    // Wait with flag already pending.
    port_a = 32'h0; cyc(3); port_a = 32'h2; cyc(3);
    wait_req = 1'b1; cyc(1);
    chk("R8 done next cycle", wait_done, 1);
    chk("R8 flag consumed", evt_pending, 0);
    wait_req = 1'b0; cyc(1);
    chk("R8 done single pulse", wait_done, 0);

    // Wait issued before the event.
    port_a = 32'h0; cyc(3);
    wait_req = 1'b1; cyc(4);
    chk("R9 no done without event", wait_done, 0);
    port_a = 32'h2; cyc(1);
    chk("R9 done low before flag", wait_done, 0);
    cyc(1);
    chk("R9 flag set", evt_pending, 1);
    chk("R9 done not yet", wait_done, 0);
    cyc(1);
    chk("R9 done after flag", wait_done, 1);
    chk("R9 flag consumed", evt_pending, 0);
    wait_req = 1'b0; cyc(1);
    chk("R9 done ends", wait_done, 0);

    // Sweep over senses, port choice, masks, values and 3-bit transitions.
    for (int s = 0; s < 2; s++)
      for (int sel = 0; sel < 2; sel++)
        for (int mi = 0; mi < 3; mi++)
          for (int v = 0; v < 8; v++)
            for (int o = 0; o < 8; o++)
              for (int n = 0; n < 8; n++) begin
                logic [31:0] m, oldv, newv;
                bit expv;
                m = (mi == 0) ? 32'h7 : (mi == 1) ? 32'h5 : 32'h0;
                oldv = {29'h0ACE_1234, 3'(o)};
                newv = {29'h1357_9BDF, 3'(n)};
                if (sel == 1) begin port_b = oldv; port_a = ~newv; end
                else          begin port_a = oldv; port_b = ~newv; end
                load(bit'(sel), m, 32'(v), bit'(s));
                cyc(3);
                ack_pulse();
                cyc(1);
                if (sel == 1) begin port_b = newv; port_a = ~oldv; end
                else          begin port_a = newv; port_b = ~oldv; end
                cyc(3);
                expv = ref_match(newv, m, 32'(v), bit'(s)) && !ref_match(oldv, m, 32'(v), bit'(s));
                chk("R1 R2 R3 sweep", evt_pending, expv);
              end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule